// File: doc/BRIEF.md
# Vectored Interrupt Dispatch Unit

This unit performs the vector-select step of a one-byte dispatch instruction in a small 8-bit controller. When the instruction runs, the unit receives a pulse together with the per-source pending and enable flags and the address of the instruction. It picks the highest-ranked source that is both enabled and pending. It then finds that source's two-byte slot in a vector table, fetches the slot through a byte-wide synchronous read port, and returns a 15-bit jump target with a one-cycle completion strobe.

The table occupies the last 32 bytes of a 256-byte page. Normally this is the page that holds the dispatch instruction. When the instruction sits on the final byte of its page, the table is taken from the next page instead. If no source qualifies, the lowest-ranked slot serves as the default destination. Saving context, clearing flags and returning from the interrupt are left to the surrounding core.

Top module: `vid_dispatch`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `done` is 0, `mem_rd_en` is 0 and `target` is 0.
- R2: A source counts as eligible when both its pending bit and its enable bit are 1. Among the eligible sources, the one with the highest index (15 down to 0) is selected.
- R3: Source 15 is the software trap. It is eligible whenever its pending bit is 1, whatever its enable bit says.
- R4: When no source is eligible, source 0 is selected.
- R5: Source index i maps to the slot whose low address byte is 0xE0 + 2*i. The high byte is read first, from that even address. The low byte is read on the next cycle, from the address one higher.
- R6: The page (address bits 14:8) of the slot equals the page of `instr_addr`, except when `instr_addr[7:0]` is 0xFF. In that case the page is one higher, and page 0x7F wraps to 0x00.
- R7: `target` equals {high_byte[6:0], low_byte}. Bit 7 of the high byte has no effect.
- R8: Read data is valid one cycle after `mem_rd_en`. Suppose `start` is sampled at clock edge n. Then the high read is issued in the cycle after edge n, and the low read in the cycle after edge n+1. `mem_rd_en` is low in the cycle after edge n+2. `done` is high for exactly the one cycle after edge n+3.
- R9: `pend`, `en` and `instr_addr` are sampled only at the edge that accepts `start`. Changes to them during a dispatch, and a `start` pulse that arrives while a dispatch is in progress, have no effect.
- R10: `target` holds its value from the `done` cycle until the next dispatch completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Dispatch request pulse, accepted when idle |
| pend | input | 16 | Per-source pending flags |
| en | input | 16 | Per-source enable flags |
| instr_addr | input | 15 | Address of the dispatch instruction |
| mem_rd_en | output | 1 | Byte read request |
| mem_addr | output | 15 | Byte read address |
| mem_rdata | input | 8 | Read data, valid one cycle after the request |
| done | output | 1 | One-cycle completion strobe |
| target | output | 15 | Selected jump target |

## Verification
The bench goes after the page-end corner. An instruction at offset 0xFF, including the top of memory at 0x7FFF, must move the table to the next page. A design that ignored this would fetch from the wrong page, and one that did not wrap would produce an address outside the space. It covers the software trap both with its enable bit clear and alongside other pending sources. A design that masked the trap would fall to the default slot or to a lower source. It also covers the case where no source qualifies, which must land on slot 0xE0 and not on an arbitrary index. Finally, it scrambles the flags and pulses `start` during a dispatch, then checks that the read addresses, the strobe timing and the held target come only from the values sampled at the start edge. It also checks that table bytes with bit 7 set do not leak into the target.

// File: rtl/vid_pkg.sv
`timescale 1ns/1ps
package vid_pkg;
  localparam int unsigned DEF_N_SRC  = 16;
  localparam int unsigned DEF_ADDR_W = 15;
  localparam logic [7:0]  DEF_TBL_OFS = 8'hE0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RD_HI = 2'd1,
    ST_RD_LO = 2'd2,
    ST_FIN   = 2'd3
  } vid_state_e;
endpackage

// File: rtl/vid_prio.sv
`timescale 1ns/1ps
module vid_prio #(
  parameter int unsigned N_SRC = vid_pkg::DEF_N_SRC,
  parameter int unsigned IW    = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] pend,
  input  logic [N_SRC-1:0] en,
  output logic [IW-1:0]    idx,
  output logic             any_hit
);
  logic [N_SRC-1:0] eligible;

  // Source N_SRC-1 is the software trap: pending alone qualifies it.
  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_elig
      if (g == N_SRC - 1) begin : g_trap
        assign eligible[g] = pend[g];
      end else begin : g_mask
        assign eligible[g] = pend[g] & en[g];
      end
    end
  endgenerate

  // Ascending scan: the last hit, i.e. the highest rank, wins.
  always_comb begin
    idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (eligible[i]) idx = IW'(i);
    end
  end

  assign any_hit = |eligible;

  // R2
  top_rank_chk: assert property (@(posedge clk) disable iff (rst)
    any_hit |-> ((eligible >> idx) == N_SRC'(1)));
  // R4
  default_idx_chk: assert property (@(posedge clk) disable iff (rst)
    !any_hit |-> (idx == '0));
endmodule

// File: rtl/vid_addr.sv
`timescale 1ns/1ps
module vid_addr #(
  parameter int unsigned ADDR_W  = vid_pkg::DEF_ADDR_W,
  parameter int unsigned IW      = 4,
  parameter logic [7:0]  TBL_OFS = vid_pkg::DEF_TBL_OFS
) (
  input  logic [ADDR_W-1:0] instr_addr,
  input  logic [IW-1:0]     idx,
  output logic [ADDR_W-1:0] entry,
  output logic              page_adv
);
  localparam int unsigned PW = ADDR_W - 8;

  function automatic logic [PW-1:0] table_page(input logic [ADDR_W-1:0] ia);
    logic [PW-1:0] pg;
    pg = ia[ADDR_W-1:8];
    if (ia[7:0] == 8'hFF) pg = pg + PW'(1);
    return pg;
  endfunction

  function automatic logic [7:0] slot_offset(input logic [IW-1:0] i);
    return TBL_OFS + 8'({i, 1'b0});
  endfunction

  assign page_adv = (instr_addr[7:0] == 8'hFF);
  assign entry    = {table_page(instr_addr), slot_offset(idx)};
endmodule

// File: rtl/vid_seq.sv
`timescale 1ns/1ps
module vid_seq #(
  parameter int unsigned ADDR_W = vid_pkg::DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] entry_in,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              done,
  output logic [ADDR_W-1:0] target,
  output logic              accept_ev,
  output logic              rd_hi_ev,
  output logic              rd_lo_ev,
  output logic              fin_ev
);
  import vid_pkg::*;
  localparam int unsigned HB = ADDR_W - 8;

  vid_state_e        state;
  logic [ADDR_W-1:0] entry_q;
  logic [7:0]        hi_q;
  logic [ADDR_W-1:0] target_q;
  logic              done_q;

  function automatic logic [ADDR_W-1:0] join_target(input logic [7:0] hi,
                                                     input logic [7:0] lo);
    return {hi[HB-1:0], lo};
  endfunction

  assign accept_ev = (state == ST_IDLE) && start;
  assign rd_hi_ev  = (state == ST_RD_HI);
  assign rd_lo_ev  = (state == ST_RD_LO);
  assign fin_ev    = (state == ST_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      entry_q  <= '0;
      hi_q     <= '0;
      target_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            entry_q <= entry_in;
            state   <= ST_RD_HI;
          end
        end
        ST_RD_HI: state <= ST_RD_LO;
        ST_RD_LO: begin
          hi_q  <= mem_rdata;
          state <= ST_FIN;
        end
        ST_FIN: begin
          target_q <= join_target(hi_q, mem_rdata);
          done_q   <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_rd_en = rd_hi_ev | rd_lo_ev;
  assign mem_addr  = rd_lo_ev ? {entry_q[ADDR_W-1:1], 1'b1} : entry_q;
  assign done      = done_q;
  assign target    = target_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  accept_read_chk: assert property (@(posedge clk) disable iff (rst)
    accept_ev |=> rd_hi_ev);
  // R5
  rd_order_chk: assert property (@(posedge clk) disable iff (rst)
    rd_hi_ev |=> (rd_lo_ev && mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));
  // R8
  fin_done_chk: assert property (@(posedge clk) disable iff (rst)
    fin_ev |=> done);
  // R10
  tgt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(target));
endmodule

// File: rtl/vid_dispatch.sv
`timescale 1ns/1ps
module vid_dispatch #(
  parameter int unsigned N_SRC   = vid_pkg::DEF_N_SRC,
  parameter int unsigned ADDR_W  = vid_pkg::DEF_ADDR_W,
  parameter logic [7:0]  TBL_OFS = vid_pkg::DEF_TBL_OFS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [N_SRC-1:0]  pend,
  input  logic [N_SRC-1:0]  en,
  input  logic [ADDR_W-1:0] instr_addr,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              done,
  output logic [ADDR_W-1:0] target
);
  localparam int unsigned IW = $clog2(N_SRC);

  logic [IW-1:0]     sel_idx;
  logic              any_hit;
  logic [ADDR_W-1:0] entry;
  logic              page_adv;
  logic              accept_ev, rd_hi_ev, rd_lo_ev, fin_ev;

  vid_prio #(.N_SRC(N_SRC), .IW(IW)) u_prio (
    .clk(clk), .rst(rst), .pend(pend), .en(en),
    .idx(sel_idx), .any_hit(any_hit)
  );

  vid_addr #(.ADDR_W(ADDR_W), .IW(IW), .TBL_OFS(TBL_OFS)) u_addr (
    .instr_addr(instr_addr), .idx(sel_idx),
    .entry(entry), .page_adv(page_adv)
  );

  vid_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .entry_in(entry),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .done(done), .target(target),
    .accept_ev(accept_ev), .rd_hi_ev(rd_hi_ev),
    .rd_lo_ev(rd_lo_ev), .fin_ev(fin_ev)
  );

  // R5
  tbl_window_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (mem_addr[7:0] >= TBL_OFS));
  // R6
  page_same_chk: assert property (@(posedge clk) disable iff (rst)
    (accept_ev && !page_adv) |=> (mem_addr[ADDR_W-1:8] == $past(instr_addr[ADDR_W-1:8])));
  // R6
  page_next_chk: assert property (@(posedge clk) disable iff (rst)
    (accept_ev && page_adv) |=>
      (mem_addr[ADDR_W-1:8] == (ADDR_W-8)'($past(instr_addr[ADDR_W-1:8]) + 1'b1)));
  // R4
  default_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (accept_ev && !any_hit) |=> (mem_addr[7:0] == TBL_OFS));
endmodule

// File: tb/sim_vid_dispatch.sv
`timescale 1ns/1ps
module sim_vid_dispatch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] pend = '0;
  logic [15:0] en = '0;
  logic [14:0] instr_addr = '0;
  logic        mem_rd_en;
  logic [14:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        done;
  logic [14:0] target;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  vid_dispatch u0 (
    .clk(clk), .rst(rst), .start(start), .pend(pend), .en(en),
    .instr_addr(instr_addr), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .done(done), .target(target)
  );

  // Table contents are a fixed arithmetic function of the address.
  function automatic logic [7:0] mbyte(input logic [14:0] a);
    return (a[7:0] * 8'd37) ^ {1'b0, a[14:8]};
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rdata <= mbyte(mem_addr);

  function automatic int pick(input logic [15:0] p, input logic [15:0] e);
    for (int i = 15; i >= 0; i--) begin
      if (p[i] && (e[i] || i == 15)) return i;
    end
    return 0;
  endfunction

  function automatic logic [14:0] slot_of(input logic [14:0] ia, input int i);
    logic [6:0] pg;
    pg = ia[14:8];
    if (ia[7:0] == 8'd255) pg = pg + 7'd1;
    return {pg, 8'd224 + 8'(2 * i)};
  endfunction

  function automatic logic [14:0] tgt_of(input logic [14:0] s);
    logic [7:0] h;
    h = mbyte(s);
    return {h[6:0], mbyte(s + 15'd1)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic dispatch(input logic [15:0] p, input logic [15:0] e,
                          input logic [14:0] ia, input bit poke, input string req);
    logic [14:0] s, t;
    s = slot_of(ia, pick(p, e));
    t = tgt_of(s);
    @(negedge clk);
    start = 1'b1; pend = p; en = e; instr_addr = ia;
    @(negedge clk);
    // R9: scramble the inputs once the request has been taken
    start = poke; pend = ~p; en = ~e; instr_addr = ia ^ 15'h0101;
    chk(mem_rd_en && mem_addr == s, {req, "/R5 hi read"}, int'(mem_addr), int'(s));
    @(negedge clk);
    start = 1'b0;
    chk(mem_rd_en && mem_addr == (s | 15'd1), "R5 lo read", int'(mem_addr), int'(s | 15'd1));
    @(negedge clk);
    chk(!mem_rd_en && !done, "R8 gap", int'({mem_rd_en, done}), 0);
    @(negedge clk);
    chk(done == 1'b1, "R8 done", int'(done), 1);
    chk(target == t, {req, "/R7 target"}, int'(target), int'(t));
    @(negedge clk);
    chk(!done && !mem_rd_en, "R8/R9 single pulse", int'({done, mem_rd_en}), 0);
    chk(target == t, "R10 hold", int'(target), int'(t));
  endtask

  initial begin
    logic [15:0] lf;
    logic [14:0] last_t;
    repeat (3) @(negedge clk);
    // R1
    chk(!done && !mem_rd_en && target == '0, "R1 in reset", int'({done, mem_rd_en, target}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !mem_rd_en && target == '0, "R1 after reset", int'({done, mem_rd_en, target}), 0);

    // R2: each rank as top, with lower-rank noise
    for (int i = 0; i < 16; i++) begin
      dispatch(16'(1 << i) | (16'((1 << i) - 1) & 16'h5555), 16'hFFFF,
               15'h0100 + 15'(i * 3), 1'b0, "R2");
    end
    // R2: higher pending sources masked off
    dispatch(16'h7FFF, 16'h0010, 15'h0230, 1'b0, "R2 masked");
    // R3: trap with enable clear
    dispatch(16'h8000, 16'h0000, 15'h0400, 1'b0, "R3");
    dispatch(16'h8001, 16'h0001, 15'h0410, 1'b1, "R3");
    // R4: nothing eligible
    dispatch(16'h0000, 16'hFFFF, 15'h0500, 1'b0, "R4");
    dispatch(16'h7FFF, 16'h0000, 15'h0520, 1'b0, "R4");
    dispatch(16'h00F0, 16'h0F0F, 15'h05FE, 1'b0, "R4");
    // R6: page-end cases, including wrap of the top page
    dispatch(16'h0004, 16'h0004, 15'h01FF, 1'b0, "R6");
    dispatch(16'h0004, 16'h0004, 15'h00FF, 1'b0, "R6");
    dispatch(16'h8000, 16'h0000, 15'h7FFF, 1'b0, "R6 wrap");
    dispatch(16'h0000, 16'h0000, 15'h7FFF, 1'b0, "R6 wrap");
    dispatch(16'h0200, 16'h0200, 15'h3300, 1'b0, "R6");
    dispatch(16'h0200, 16'h0200, 15'h33FE, 1'b0, "R6");

    // R10: target held while idle
    last_t = target;
    repeat (6) @(negedge clk);
    chk(target == last_t && !done, "R10 idle hold", int'(target), int'(last_t));

    // R2/R7/R9 sweep over pseudo-random flags and addresses
    lf = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      logic [15:0] p, e;
      logic [14:0] ia;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      p = lf;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      e = lf;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ia = (k % 7 == 0) ? {lf[14:8], 8'hFF} : lf[14:0];
      dispatch(p & (k % 3 == 0 ? 16'h7FFF : 16'hFFFF), e, ia, (k % 5 == 0), "R2 sweep");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule